// File: doc/BRIEF.md
# Compare-Driven PWM Timer

A 16-bit up-counter paced by a selectable prescaler, with two byte-programmable compare channels that shape a waveform on a single output pin. Channel 1 marks the duty edge and channel 2 marks the period edge. In PWM mode a channel 2 match reloads the counter to FFFCh instead of 0000h. This offset makes the compare value for a wanted period equal to the number of ticks minus five.

Software programs the block through a byte-wide write port. Each compare value is written as a high byte and a low byte. Writing the high byte disarms that channel until the low byte arrives, so a half-updated value can never produce a match. Outside PWM mode each match gives a one-cycle event pulse. In PWM mode those pulses are suppressed. One-pulse mode is ignored whenever PWM mode is also set.

Top module: `pwm_timer_top`

## Requirements
- R1: While reset is held, count reads FFFCh, cmp_out reads 0 and both event outputs read 0. Both compare values reset to FFFFh and are armed, and all control fields reset to 0.
- R2: The counter advances by one on each prescaled tick and wraps from FFFFh to 0000h. The clock-select field is bits 3:2 of address 1. Its encodings are: 00 = one tick every 4 clocks, 01 = one tick every 2 clocks, 10 = one tick every 8 clocks, 11 = a tick on each clock with ext_tick high.
- R3: On a tick where the counter equals compare 1 (armed), the pin takes the duty level, which is bit 1 of address 0.
- R4: In PWM mode (bit 0 of address 1), a tick where the counter equals compare 2 (armed) sets the pin to the period level (bit 0 of address 0) and reloads the counter to FFFCh. With period level 0 and duty level 1, the pin stays low for compare1+5 ticks and high for compare2-compare1 ticks.
- R5: When both matches fall on the same tick, the compare 2 action wins in PWM mode.
- R6: A write to a compare high byte disarms that channel until its low byte is written. The addresses are: 2 = compare 1 high, 3 = compare 1 low, 4 = compare 2 high, 5 = compare 2 low. A disarmed channel produces no match.
- R7: Outside PWM mode, a tick match on compare 1 or compare 2 raises cmp1_evt or cmp2_evt for exactly one cycle. In PWM mode neither event output is ever raised.
- R8: With one-pulse mode (bit 1 of address 1) and PWM both set, the block behaves exactly as in PWM mode. With one-pulse mode alone, a compare 2 match drives the period level with no reload. With neither mode set, a compare 2 match leaves the pin and the counter unaffected.
- R9: cmp_out follows the internal pin level only while the output enable (bit 2 of address 0) is 1. Otherwise it is 0.
- R10: A write that sets PWM mode while PWM mode is off reloads the counter to FFFCh and sets the pin to the period level on the following cycle. This takes precedence over a tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External tick enable used by clock select 11 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cmp_out | output | 1 | Compare output pin |
| count | output | 16 | Current counter value |
| cmp1_evt | output | 1 | Compare 1 match pulse (outside PWM mode) |
| cmp2_evt | output | 1 | Compare 2 match pulse (outside PWM mode) |

## Verification
Two functions can fall in the same cycle: the duty match and the period match on one tick, and the PWM-start write and a prescaled tick. The bench provokes the first by loading equal compare values with PWM running and expects the pin never to leave the period level. It provokes the second through random writes to the mode register while ext_tick fires every clock, and judges the result against a cycle-accurate model in the bench that gives the start write priority. A bound checker also tests the tie rule and the start reload directly on the internal tick.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int DIV_W = 3;
    localparam int NCH   = 2;

    typedef enum logic [1:0] {
        CLK_DIV4 = 2'b00,
        CLK_DIV2 = 2'b01,
        CLK_DIV8 = 2'b10,
        CLK_EXT  = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic out_en;
        logic duty_lvl;
        logic per_lvl;
    } lvl_cfg_t;

    typedef struct packed {
        clk_sel_e clk_sel;
        logic     opm_en;
        logic     pwm_en;
    } mode_cfg_t;

    localparam int ADDR_LVL  = 0;
    localparam int ADDR_MODE = 1;
    localparam int ADDR_CMP  = 2;

    function automatic logic [DIV_W-1:0] div_mask(input clk_sel_e sel);
        case (sel)
            CLK_DIV2: div_mask = 3'b001;
            CLK_DIV8: div_mask = 3'b111;
            default:  div_mask = 3'b011;
        endcase
    endfunction

    function automatic logic [15:0] reload_value();
        reload_value = 16'hFFFC;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     ext_tick,
    output logic     tick
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) pcnt <= '0;
        else     pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        mask = div_mask(sel);
        if (sel == CLK_EXT) tick = ext_tick;
        else                tick = ((pcnt & mask) == mask);
    end
endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
    parameter int DW     = 8,
    parameter int AW     = 3,
    parameter int HI_ADR = 2,
    localparam int CW    = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] value,
    output logic          armed
);
    localparam logic [AW-1:0] HI_A = AW'(HI_ADR);
    localparam logic [AW-1:0] LO_A = AW'(HI_ADR + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '1;
            armed <= 1'b1;
        end else if (wr_en && wr_addr == HI_A) begin
            value[CW-1:DW] <= wr_data;
            armed          <= 1'b0;
        end else if (wr_en && wr_addr == LO_A) begin
            value[DW-1:0] <= wr_data;
            armed         <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_timer_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    localparam int CW = 2 * DW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    output lvl_cfg_t                lvl,
    output mode_cfg_t               mode,
    output logic [NCH-1:0][CW-1:0]  cmp,
    output logic [NCH-1:0]          arm,
    output logic                    pwm_start
);
    localparam logic [AW-1:0] LVL_A  = AW'(ADDR_LVL);
    localparam logic [AW-1:0] MODE_A = AW'(ADDR_MODE);

    logic mode_wr;
    assign mode_wr   = wr_en && (wr_addr == MODE_A);
    assign pwm_start = mode_wr && wr_data[0] && !mode.pwm_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= '0;
            mode <= '0;
        end else begin
            if (wr_en && wr_addr == LVL_A) lvl <= lvl_cfg_t'(wr_data[2:0]);
            if (mode_wr)                   mode <= mode_cfg_t'(wr_data[3:0]);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_cmp_reg #(
            .DW     (DW),
            .AW     (AW),
            .HI_ADR (ADDR_CMP + 2 * i)
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .value   (cmp[i]),
            .armed   (arm[i])
        );
    end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   pwm_start,
    input  lvl_cfg_t               lvl,
    input  mode_cfg_t              mode,
    input  logic [NCH-1:0][CW-1:0] cmp,
    input  logic [NCH-1:0]         arm,
    output logic [CW-1:0]          cnt,
    output logic                   pin,
    output logic [NCH-1:0]         evt
);
    localparam logic [CW-1:0] RELOAD = CW'(reload_value());

    logic [NCH-1:0] hit;
    logic           pwm_on;
    logic           opm_on;

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        assign hit[i] = tick && arm[i] && (cnt == cmp[i]);
    end

    assign pwm_on = mode.pwm_en;
    assign opm_on = mode.opm_en && !mode.pwm_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RELOAD;
            pin <= 1'b0;
            evt <= '0;
        end else begin
            evt <= pwm_on ? '0 : hit;
            if (pwm_start) begin
                cnt <= RELOAD;
                pin <= lvl.per_lvl;
            end else if (tick) begin
                if (hit[1] && pwm_on) begin
                    cnt <= RELOAD;
                    pin <= lvl.per_lvl;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (hit[1] && opm_on) pin <= lvl.per_lvl;
                    else if (hit[0])      pin <= lvl.duty_lvl;
                end
            end
        end
    end
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          cmp_out,
    output logic [CW-1:0] count,
    output logic          cmp1_evt,
    output logic          cmp2_evt
);
    lvl_cfg_t               lvl_cfg;
    mode_cfg_t              mode_cfg;
    logic [NCH-1:0][CW-1:0] cmp_val;
    logic [NCH-1:0]         arm;
    logic                   pwm_start;
    logic                   tick;
    logic                   pin_q;
    logic [NCH-1:0]         evt;
    logic                   pwm_on;
    logic                   per_lvl;

    pwm_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lvl       (lvl_cfg),
        .mode      (mode_cfg),
        .cmp       (cmp_val),
        .arm       (arm),
        .pwm_start (pwm_start)
    );

    pwm_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .sel      (mode_cfg.clk_sel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    pwm_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .pwm_start (pwm_start),
        .lvl       (lvl_cfg),
        .mode      (mode_cfg),
        .cmp       (cmp_val),
        .arm       (arm),
        .cnt       (count),
        .pin       (pin_q),
        .evt       (evt)
    );

    assign pwm_on   = mode_cfg.pwm_en;
    assign per_lvl  = lvl_cfg.per_lvl;
    assign cmp_out  = lvl_cfg.out_en & pin_q;
    assign cmp1_evt = evt[0];
    assign cmp2_evt = evt[1];
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          pwm_start,
    input logic          pwm_on,
    input logic          per_lvl,
    input logic [1:0]    arm,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] cmp1,
    input logic [CW-1:0] cmp2,
    input logic          pin,
    input logic [1:0]    evt
);
    localparam logic [CW-1:0] RELOAD = {{(CW-2){1'b1}}, 2'b00};

    // R7
    pwm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwm_on) |-> (evt == 2'b00));

    // R4
    period_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_on && !pwm_start && arm[1] && cnt == cmp2) |=> (cnt == RELOAD));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !pwm_start && cnt == '1 && !(pwm_on && arm[1] && cnt == cmp2))
        |=> (cnt == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !pwm_start) |=> $stable(cnt));

    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (!arm[0]) |=> !evt[0]);

    // R10
    start_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_start |=> (cnt == RELOAD && pin == $past(per_lvl)));

    // R5
    tie_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_on && !pwm_start && arm == 2'b11 && cmp1 == cmp2 && cnt == cmp2)
        |=> (pin == $past(per_lvl)));
endmodule

bind pwm_timer_top pwm_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pwm_start (pwm_start),
    .pwm_on    (pwm_on),
    .per_lvl   (per_lvl),
    .arm       (arm),
    .cnt       (count),
    .cmp1      (cmp_val[0]),
    .cmp2      (cmp_val[1]),
    .pin       (pin_q),
    .evt       (evt)
);

// File: tb/tb_pwm_timer_top.sv
module tb_pwm_timer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cmp_out;
    logic [15:0] count;
    logic        cmp1_evt;
    logic        cmp2_evt;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwm_timer_top dut (
        .clk(clk), .rst(rst), .ext_tick(ext_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_out(cmp_out), .count(count),
        .cmp1_evt(cmp1_evt), .cmp2_evt(cmp2_evt)
    );

    // ---------------- bench functions ----------------
    function automatic logic [2:0] f_mask(input logic [1:0] sel);
        case (sel)
            2'b01:   f_mask = 3'd1;
            2'b10:   f_mask = 3'd7;
            default: f_mask = 3'd3;
        endcase
    endfunction

    function automatic int f_low_len(input int c1);
        f_low_len = c1 + 5;
    endfunction

    function automatic int f_high_len(input int c1, input int c2);
        f_high_len = c2 - c1;
    endfunction

    // ---------------- reference model ----------------
    logic [15:0] m_cnt, m_c1, m_c2;
    logic        m_a1, m_a2, m_pin, m_e1, m_e2;
    logic [2:0]  m_pc;
    logic [2:0]  m_lvl;
    logic [3:0]  m_mode;

    always @(posedge clk) begin : model
        logic tk, h1, h2, pwm, opm, start;
        if (rst) begin
            m_cnt <= 16'hFFFC; m_c1 <= 16'hFFFF; m_c2 <= 16'hFFFF;
            m_a1 <= 1'b1; m_a2 <= 1'b1; m_pin <= 1'b0;
            m_e1 <= 1'b0; m_e2 <= 1'b0; m_pc <= '0; m_lvl <= '0; m_mode <= '0;
        end else begin
            m_pc <= m_pc + 3'd1;
            tk  = (m_mode[3:2] == 2'b11) ? ext_tick
                  : ((m_pc & f_mask(m_mode[3:2])) == f_mask(m_mode[3:2]));
            h1  = tk && m_a1 && (m_cnt == m_c1);
            h2  = tk && m_a2 && (m_cnt == m_c2);
            pwm = m_mode[0];
            opm = m_mode[1] && !m_mode[0];
            start = wr_en && wr_addr == 3'd1 && wr_data[0] && !pwm;
            m_e1 <= pwm ? 1'b0 : h1;
            m_e2 <= pwm ? 1'b0 : h2;
            if (start) begin
                m_cnt <= 16'hFFFC; m_pin <= m_lvl[0];
            end else if (tk) begin
                if (h2 && pwm) begin
                    m_cnt <= 16'hFFFC; m_pin <= m_lvl[0];
                end else begin
                    m_cnt <= m_cnt + 16'd1;
                    if (h2 && opm) m_pin <= m_lvl[0];
                    else if (h1)   m_pin <= m_lvl[1];
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_lvl  <= wr_data[2:0];
                    3'd1: m_mode <= wr_data[3:0];
                    3'd2: begin m_c1[15:8] <= wr_data; m_a1 <= 1'b0; end
                    3'd3: begin m_c1[7:0]  <= wr_data; m_a1 <= 1'b1; end
                    3'd4: begin m_c2[15:8] <= wr_data; m_a2 <= 1'b0; end
                    3'd5: begin m_c2[7:0]  <= wr_data; m_a2 <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    bit lockstep = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (lockstep && !rst) begin
            chk(count == m_cnt, "R2 counter vs model", int'(count), int'(m_cnt));
            chk(cmp_out == (m_pin & m_lvl[2]), "R3 pin vs model",
                int'(cmp_out), int'(m_pin & m_lvl[2]));
            chk({cmp2_evt, cmp1_evt} == {m_e2, m_e1}, "R7 events vs model",
                int'({cmp2_evt, cmp1_evt}), int'({m_e2, m_e1}));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_cmp(input int ch, input logic [15:0] v);
        wr(3'(2 + 2 * ch), v[15:8]);
        wr(3'(3 + 2 * ch), v[7:0]);
    endtask

    task automatic wait_level(input logic v);
        int n = 0;
        while (cmp_out != v && n < 2000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (cmp_out == v && n < 2000) begin
            n++; @(negedge clk);
        end
    endtask

    task automatic window(input int len, output int highs, output int evts, output int e1s);
        highs = 0; evts = 0; e1s = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (cmp_out) highs++;
            if (cmp1_evt || cmp2_evt) evts++;
            if (cmp1_evt) e1s++;
        end
    endtask

    task automatic div_test(input logic [1:0] sel, input int span, input int exp, input string tag);
        logic [15:0] c0;
        wr(3'd1, {4'b0, sel, 2'b00});
        c0 = count;
        repeat (span) @(negedge clk);
        chk(16'(count - c0) == 16'(exp), tag, int'(16'(count - c0)), exp);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int hi, lo, hs, ev, e1;
        logic [15:0] t;
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(count == 16'hFFFC, "R1 reset count", int'(count), 16'hFFFC);
        chk(cmp_out == 1'b0, "R1 reset pin", int'(cmp_out), 0);
        chk({cmp2_evt, cmp1_evt} == 2'b00, "R1 reset events", int'({cmp2_evt, cmp1_evt}), 0);
        rst = 1'b0;
        lockstep = 1'b1;

        // R2: prescale encodings in plain mode
        div_test(2'b01, 40, 20, "R2 divide by 2");
        div_test(2'b00, 40, 10, "R2 divide by 4");
        div_test(2'b10, 80, 10, "R2 divide by 8");
        ext_tick = 1'b0;
        div_test(2'b11, 40, 0, "R2 external tick low");
        ext_tick = 1'b1;
        div_test(2'b11, 40, 40, "R2 external tick high");

        // R10: PWM start reloads and applies the period level
        wr(3'd0, 8'h05);
        wr_cmp(0, 16'd10);
        wr_cmp(1, 16'd30);
        wr(3'd1, 8'h0C);
        wr(3'd1, 8'h0D);
        chk(count == 16'hFFFC, "R10 start reload", int'(count), 16'hFFFC);
        chk(cmp_out == 1'b1, "R10 start level", int'(cmp_out), 1);

        // R3/R4: waveform lengths with period level 0, duty level 1
        wr(3'd0, 8'h06);
        wait_level(1'b0);
        wait_level(1'b1);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        chk(hi == f_high_len(10, 30), "R3 duty-level run", hi, f_high_len(10, 30));
        chk(lo == f_low_len(10), "R4 period-level run", lo, f_low_len(10));

        // R9 and R7: output disabled, no events in PWM
        wr(3'd0, 8'h02);
        window(120, hs, ev, e1);
        chk(hs == 0, "R9 pin idle while disabled", hs, 0);
        chk(ev == 0, "R7 no events in PWM mode", ev, 0);

        // R5: equal compare values, period action wins
        wr(3'd1, 8'h0C);
        wr_cmp(0, 16'd20);
        wr_cmp(1, 16'd20);
        wr(3'd0, 8'h06);
        wr(3'd1, 8'h0D);
        window(150, hs, ev, e1);
        chk(hs == 0, "R5 tie keeps period level", hs, 0);

        // R8: one-pulse together with PWM behaves as PWM
        wr(3'd1, 8'h0C);
        wr_cmp(0, 16'd10);
        wr_cmp(1, 16'd30);
        wr(3'd1, 8'h0F);
        wait_level(1'b1);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        chk(hi + lo == 35, "R8 PWM overrides one-pulse", hi + lo, 35);

        // R8: one-pulse alone: period level, no reload
        wr(3'd1, 8'h0E);
        t = count;
        wr_cmp(0, t + 16'd20);
        wr_cmp(1, t + 16'd40);
        window(70, hs, ev, e1);
        chk(hs > 0, "R8 one-pulse duty edge seen", hs, 1);
        chk(cmp_out == 1'b0, "R8 one-pulse period level", int'(cmp_out), 0);
        chk(16'(count - (t + 16'd40)) < 16'd60 && count != 16'hFFFC,
            "R8 one-pulse no reload", int'(count), int'(t + 16'd40));

        // R6: high-byte write disarms, low byte rearms (plain mode)
        wr(3'd1, 8'h0C);
        t = count + 16'd40;
        wr(3'd2, t[15:8] ^ 8'h80);
        wr(3'd3, t[7:0]);
        wr(3'd2, t[15:8]);
        window(80, hs, ev, e1);
        chk(e1 == 0, "R6 disarmed compare silent", e1, 0);
        t = count + 16'd30;
        wr_cmp(0, t);
        window(80, hs, ev, e1);
        chk(e1 == 1, "R6 rearmed compare single pulse R7", e1, 1);

        // constrained random phase checked by the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ext_tick = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) begin
                logic [2:0] a;
                a = 3'($urandom_range(0, 5));
                wr_en = 1'b1; wr_addr = a;
                if (a == 3'd2 || a == 3'd4) wr_data = 8'($urandom_range(0, 1) == 0 ? 0 : 8'hFF);
                else if (a == 3'd1)         wr_data = 8'($urandom_range(0, 15));
                else                        wr_data = 8'($urandom_range(0, 63));
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule